// File: doc/BRIEF.md
# Overlay Code Sequencer

This block holds two binary overlay codes. Code 0 serves the pilot channel and code 1 the data channel. A host loads both codes through a simple register write port. A period pulse marks every boundary of the primary spreading code. On each pulse the block presents the current chip of each code as a registered output. Downstream correlator logic uses these chips to invert the sign of its products while integrating coherently over several primary periods.

The block also counts primary periods to mark the end of each coherent integration block. The first block after an index reset has one programmed length, and every later block uses a second length. A control register has three bits:
- one gates the sample stream;
- one enables the codes;
- one resets both code indices and restarts the block count.

Writing the enable bit without the reset bit keeps both code indices running from where they stopped. The codes then stay aligned across consecutive integration blocks.

Top module: `overlay_code_seq`

## Requirements
- R1: After reset, `code0_chip`, `code1_chip`, `sample_release` and `block_done` are all 0.
- R2: A write to select 2 (code 0) or select 3 (code 1) stores a word only when `cfg_wdata[23]` is 1. Bits 19:0 carry the data, and bits 22:20 carry the word address w. Data bit k becomes chip w*20+k. A write with bit 23 clear leaves the code unchanged.
- R3: The two codes live in separate memories. A write to one code never changes the chips produced by the other.
- R4: A write to select 1 sets the code 0 length minus one from bits 7:0 and the code 1 length minus one from bits 15:8. A field above 159 is clamped to 159, so the code length is 160.
- R5: On a `period_tick` while enabled, the chip at the current index of each code appears on its output after the next clock edge. The index then advances by one and returns to 0 after length minus one.
- R6: A write to select 0 sets `sample_release` to `cfg_wdata[0]` from the next clock edge on.
- R7: A select 0 write with `cfg_wdata[2]` set puts both code indices at 0, so the next tick presents chip 0. It also restarts the block count with the first length.
- R8: A select 0 write with `cfg_wdata[1]` set and `cfg_wdata[2]` clear enables the codes and keeps both indices where they were.
- R9: While `cfg_wdata[1]` of the last control write is 0, both chip outputs read 0 after the next tick. Ticks do not advance the indices or the block count.
- R10: Select 4 holds the first block length minus one and select 5 the next block length minus one, both counted in ticks. `block_done` pulses for one cycle after the tick that completes a block. The first block after R7 takes first+1 ticks, and every later block takes next+1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 control, 1 lengths, 2 code 0, 3 code 1, 4 first length, 5 next length) |
| cfg_wdata | input | 24 | Register write data |
| period_tick | input | 1 | One-cycle pulse at each primary code boundary |
| sample_release | output | 1 | Sample stream gate |
| code0_chip | output | 1 | Current chip of code 0 |
| code1_chip | output | 1 | Current chip of code 1 |
| block_done | output | 1 | One-cycle pulse at the end of an integration block |

## Verification
The bench uses the default parameters: 20-bit words and a 3-bit word address, for 160 chips per code. With these values, full-length codes, lengths of 20 and 21 that cross a word boundary, and the clamp of an oversized length field can all be reached. The 16-bit block counters are loaded with small values, so first and later block ends occur many times within each run of ticks.

// File: rtl/ovl_seq_pkg.sv
package ovl_seq_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_LENS  = 3'd1,
    SEL_CODE0 = 3'd2,
    SEL_CODE1 = 3'd3,
    SEL_FIRST = 3'd4,
    SEL_NEXT  = 3'd5
  } reg_sel_e;

  localparam int CTRL_RELEASE = 0;
  localparam int CTRL_ENABLE  = 1;
  localparam int CTRL_INIT    = 2;
  localparam int NUM_CODES    = 2;
endpackage

// File: rtl/ovl_code_lane.sv
module ovl_code_lane #(
  parameter int WORD_BITS = 20,
  parameter int ADDR_BITS = 3,
  localparam int NUM_WORDS = 1 << ADDR_BITS,
  localparam int MAX_CHIPS = WORD_BITS * NUM_WORDS,
  localparam int IDX_W     = $clog2(MAX_CHIPS),
  localparam int BIT_W     = $clog2(WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_word_i,
  input  logic [ADDR_BITS-1:0] wr_addr_i,
  input  logic [WORD_BITS-1:0] wr_data_i,
  input  logic [IDX_W-1:0]     len_m1_i,
  input  logic                 en_i,
  input  logic                 init_i,
  input  logic                 tick_i,
  output logic                 chip_o
);
  logic [WORD_BITS-1:0] mem_q [NUM_WORDS];
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [ADDR_BITS-1:0] word_q, word_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic                 chip_q, chip_d;
  logic                 advance;
  logic                 at_end;

  assign advance = en_i && tick_i;
  assign at_end  = (idx_q >= len_m1_i);

  always_comb begin
    idx_d  = idx_q;
    word_d = word_q;
    bit_d  = bit_q;
    if (init_i) begin
      idx_d  = '0;
      word_d = '0;
      bit_d  = '0;
    end else if (advance) begin
      if (at_end) begin
        idx_d  = '0;
        word_d = '0;
        bit_d  = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
        if (bit_q == BIT_W'(WORD_BITS - 1)) begin
          bit_d  = '0;
          word_d = word_q + ADDR_BITS'(1);
        end else begin
          bit_d = bit_q + BIT_W'(1);
        end
      end
    end
  end

  always_comb begin
    if (!en_i)       chip_d = 1'b0;
    else if (tick_i) chip_d = mem_q[word_q][bit_q];
    else             chip_d = chip_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      word_q <= '0;
      bit_q  <= '0;
      chip_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      word_q <= word_d;
      bit_q  <= bit_d;
      chip_q <= chip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) mem_q[w] <= '0;
    end else if (wr_word_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign chip_o = chip_q;

  AST_INIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (idx_q == '0)) else $error("index not cleared"); // R7
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !init_i) |=> $stable(idx_q)) else $error("index moved while off"); // R9
  AST_OFF_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !chip_o) else $error("chip set while off"); // R9
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !init_i) |=> (idx_q <= $past(len_m1_i))) else $error("index past length"); // R5
endmodule

// File: rtl/ovl_block_timer.sv
module ovl_block_timer #(
  parameter int CNT_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_BITS-1:0] first_m1_i,
  input  logic [CNT_BITS-1:0] next_m1_i,
  input  logic                en_i,
  input  logic                init_i,
  input  logic                tick_i,
  output logic                done_o
);
  logic [CNT_BITS-1:0] cnt_q, cnt_d;
  logic                done_q, done_d;
  logic                step;

  assign step = en_i && tick_i && !init_i;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (init_i) begin
      cnt_d = first_m1_i;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_d  = next_m1_i;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_BITS'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(tick_i) && $past(en_i))) else $error("done without tick"); // R10
  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (cnt_q == $past(first_m1_i))) else $error("first length not loaded"); // R7
endmodule

// File: rtl/overlay_code_seq.sv
module overlay_code_seq
  import ovl_seq_pkg::*;
#(
  parameter int WORD_BITS = 20,
  parameter int ADDR_BITS = 3,
  parameter int LEN_BITS  = 8,
  parameter int CNT_BITS  = 16,
  localparam int DATA_W    = WORD_BITS + ADDR_BITS + 1,
  localparam int STROBE    = WORD_BITS + ADDR_BITS,
  localparam int MAX_CHIPS = WORD_BITS * (1 << ADDR_BITS),
  localparam int IDX_W     = $clog2(MAX_CHIPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              period_tick,
  output logic              sample_release,
  output logic              code0_chip,
  output logic              code1_chip,
  output logic              block_done
);
  logic                release_q, release_d;
  logic                enable_q, enable_d;
  logic [IDX_W-1:0]    len_m1_q [NUM_CODES];
  logic [IDX_W-1:0]    len_m1_d [NUM_CODES];
  logic [CNT_BITS-1:0] first_q, first_d, next_q, next_d;
  logic                ctrl_wr, init_pulse;
  logic [NUM_CODES-1:0] chips;

  function automatic logic [IDX_W-1:0] clamp_len(input logic [LEN_BITS-1:0] f);
    if (int'(f) > MAX_CHIPS - 1) return IDX_W'(MAX_CHIPS - 1);
    else                         return IDX_W'(f);
  endfunction

  assign ctrl_wr    = cfg_we && (cfg_sel == SEL_CTRL);
  assign init_pulse = ctrl_wr && cfg_wdata[CTRL_INIT];

  always_comb begin
    release_d = release_q;
    enable_d  = enable_q;
    first_d   = first_q;
    next_d    = next_q;
    for (int g = 0; g < NUM_CODES; g++) len_m1_d[g] = len_m1_q[g];
    if (ctrl_wr) begin
      release_d = cfg_wdata[CTRL_RELEASE];
      enable_d  = cfg_wdata[CTRL_ENABLE];
    end
    if (cfg_we && cfg_sel == SEL_LENS) begin
      for (int g = 0; g < NUM_CODES; g++)
        len_m1_d[g] = clamp_len(cfg_wdata[g*LEN_BITS +: LEN_BITS]);
    end
    if (cfg_we && cfg_sel == SEL_FIRST) first_d = cfg_wdata[CNT_BITS-1:0];
    if (cfg_we && cfg_sel == SEL_NEXT)  next_d  = cfg_wdata[CNT_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
      enable_q  <= 1'b0;
      first_q   <= '0;
      next_q    <= '0;
      for (int g = 0; g < NUM_CODES; g++) len_m1_q[g] <= '0;
    end else begin
      release_q <= release_d;
      enable_q  <= enable_d;
      first_q   <= first_d;
      next_q    <= next_d;
      for (int g = 0; g < NUM_CODES; g++) len_m1_q[g] <= len_m1_d[g];
    end
  end

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lane
    logic prog_we;
    assign prog_we = cfg_we && cfg_wdata[STROBE] &&
                     (cfg_sel == ((g == 0) ? SEL_CODE0 : SEL_CODE1));
    ovl_code_lane #(
      .WORD_BITS (WORD_BITS),
      .ADDR_BITS (ADDR_BITS)
    ) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_word_i (prog_we),
      .wr_addr_i (cfg_wdata[WORD_BITS +: ADDR_BITS]),
      .wr_data_i (cfg_wdata[WORD_BITS-1:0]),
      .len_m1_i  (len_m1_q[g]),
      .en_i      (enable_q),
      .init_i    (init_pulse),
      .tick_i    (period_tick),
      .chip_o    (chips[g])
    );
  end

  ovl_block_timer #(
    .CNT_BITS (CNT_BITS)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_m1_i (first_q),
    .next_m1_i  (next_q),
    .en_i       (enable_q),
    .init_i     (init_pulse),
    .tick_i     (period_tick),
    .done_o     (block_done)
  );

  assign sample_release = release_q;
  assign code0_chip     = chips[0];
  assign code1_chip     = chips[1];

  AST_RELEASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (sample_release == $past(cfg_wdata[CTRL_RELEASE]))) else $error("release mismatch"); // R6
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_LENS) |=> (int'(len_m1_q[0]) <= MAX_CHIPS - 1)) else $error("length not clamped"); // R4
endmodule

// File: tb/overlay_code_seq_tb_top.sv
module overlay_code_seq_tb_top;
  localparam int NCH = 160;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic        period_tick = 1'b0;
  logic        sample_release, code0_chip, code1_chip, block_done;

  int checks = 0;
  int errors = 0;

  bit code_m [2][NCH];
  int len_m [2];
  int idx_m [2];
  int cnt_m, first_m, next_m;
  bit en_m;

  always #5 clk = ~clk;

  overlay_code_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .period_tick(period_tick),
    .sample_release(sample_release), .code0_chip(code0_chip),
    .code1_chip(code1_chip), .block_done(block_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp_len(input int field);
    return (field > NCH - 1) ? NCH : field + 1;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [23:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic ctrl(input bit rel, input bit en, input bit init);
    wr(3'd0, {21'd0, init, en, rel});
    en_m = en;
    if (init) begin
      idx_m[0] = 0; idx_m[1] = 0; cnt_m = first_m;
    end
  endtask

  task automatic load_code(input int g);
    for (int w = 0; w < 8; w++) begin
      logic [19:0] d;
      d = 20'($urandom);
      for (int k = 0; k < 20; k++) code_m[g][w*20+k] = d[k];
      wr((g == 0) ? 3'd2 : 3'd3, {1'b1, 3'(w), d});
    end
  endtask

  task automatic set_lens(input int f0, input int f1);
    wr(3'd1, {8'd0, 8'(f1), 8'(f0)});
    len_m[0] = clamp_len(f0);
    len_m[1] = clamp_len(f1);
  endtask

  task automatic set_blocks(input int f, input int n);
    wr(3'd4, 24'(f)); first_m = f;
    wr(3'd5, 24'(n)); next_m = n;
  endtask

  task automatic do_tick(input string tag);
    int e0, e1, ed;
    e0 = en_m ? int'(code_m[0][idx_m[0]]) : 0;
    e1 = en_m ? int'(code_m[1][idx_m[1]]) : 0;
    ed = (en_m && cnt_m == 0) ? 1 : 0;
    if (en_m) begin
      for (int g = 0; g < 2; g++)
        idx_m[g] = (idx_m[g] >= len_m[g] - 1) ? 0 : idx_m[g] + 1;
      cnt_m = (cnt_m == 0) ? next_m : cnt_m - 1;
    end
    @(negedge clk); period_tick = 1'b1;
    @(negedge clk); period_tick = 1'b0;
    chk({tag, " code0"}, int'(code0_chip), e0);
    chk({tag, " code1"}, int'(code1_chip), e1);
    chk({tag, " R10 done"}, int'(block_done), ed);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    len_m[0] = 1; len_m[1] = 1; idx_m[0] = 0; idx_m[1] = 0;
    cnt_m = 0; first_m = 0; next_m = 0; en_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code0", int'(code0_chip), 0);
    chk("R1 code1", int'(code1_chip), 0);
    chk("R1 release", int'(sample_release), 0);
    chk("R1 done", int'(block_done), 0);

    load_code(0); load_code(1);
    set_lens(36, 159);
    set_blocks(2, 4);
    ctrl(1, 1, 1);
    chk("R6 release set", int'(sample_release), 1);
    for (int i = 0; i < 200; i++) do_tick("R5 R2 R3 run");

    // non-strobed write must not change code 0, R2
    wr(3'd2, {1'b0, 3'd0, ~{code_m[0][19], code_m[0][18], code_m[0][17], code_m[0][16],
      code_m[0][15], code_m[0][14], code_m[0][13], code_m[0][12], code_m[0][11],
      code_m[0][10], code_m[0][9], code_m[0][8], code_m[0][7], code_m[0][6],
      code_m[0][5], code_m[0][4], code_m[0][3], code_m[0][2], code_m[0][1], code_m[0][0]}});
    ctrl(1, 1, 1);
    for (int i = 0; i < 25; i++) do_tick("R2 R7 no strobe");

    // disable: outputs 0, state held, R9
    ctrl(0, 0, 0);
    chk("R6 release clear", int'(sample_release), 0);
    for (int i = 0; i < 5; i++) do_tick("R9 off");
    // re-enable without init continues, R8
    ctrl(1, 1, 0);
    for (int i = 0; i < 30; i++) do_tick("R8 resume");

    // oversized length field clamps to 160, R4
    load_code(1);
    set_lens(255, 0);
    set_blocks(0, 0);
    ctrl(1, 1, 1);
    for (int i = 0; i < 330; i++) do_tick("R4 clamp");

    // word-boundary and random rounds
    for (int r = 0; r < 6; r++) begin
      int f0, f1;
      case (r)
        0: begin f0 = 19; f1 = 20; end
        1: begin f0 = 20; f1 = 39; end
        default: begin f0 = int'($urandom_range(0, 170)); f1 = int'($urandom_range(0, 170)); end
      endcase
      load_code(r % 2);
      set_lens(f0, f1);
      set_blocks(int'($urandom_range(0, 9)), int'($urandom_range(0, 9)));
      ctrl(1, 1, 1);
      for (int i = 0; i < 100; i++) do_tick("R5 R7 R10 round");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule